// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software read and write the management registers of an Ethernet transceiver over the two-wire serial management bus (a clock output MDC and a bidirectional data line MDIO). A command word gives the register number, the transceiver address and a direction flag. For a write, a 16-bit data value comes with the command. The controller shifts out a complete management frame. It then signals completion, or a failed read, through sticky interrupt flags. Read data is held in a data register for software.

In the background the controller can also poll one transceiver. At a programmed interval it reads the standard status register (register 1) and keeps a copy of it. Bit 2 of that copy is the link state and bit 5 is auto-negotiation complete. The controller raises a flag when the copy changes, and a separate flag when a transceiver answers for the first time.

The MDC rate is set by a programmable half-period timer. The register wrapper that drives these inputs is expected to reset them to these values:
- poll address 1;
- poll interval 4;
- polling enabled;
- MDC interval 5;
- MDC timer enabled.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A frame is 64 MDC periods, each bit sent MSB first. It starts with 32 ones and the start pair 01. Next comes the opcode, 10 for a read and 01 for a write, then the 5-bit transceiver address and the 5-bit register address. After these come two turnaround bits and 16 data bits. On a write the controller drives the whole frame, with turnaround 10. On a read it releases the line (mdio_oe low) from the first turnaround bit to the end.
- R2: cmd_word bits 4..0 hold the register address, bits 9..5 the transceiver address, and bit 10 is 1 for a write. A cmd_go pulse while cmd_lock is low is accepted. cmd_lock is then high from the next cycle until the clock edge that ends the command's frame. A cmd_go pulse while cmd_lock is high is ignored.
- R3: Read data is sampled on rising MDC edges. If the line is high at the second turnaround bit, the read-error flag is set and data_reg keeps its old value. Otherwise data_reg takes the 16 bits read.
- R4: When a write command is accepted, data_reg takes wr_data.
- R5: flags bit 0 = command complete, bit 1 = read error, bit 2 = status changed, bit 3 = transceiver detected. Flags are sticky and are cleared by writing 1 to the matching bit of flag_clr. A flag being set in the same cycle wins over a clear. Command complete is set at the end of every software frame.
- R6: irq is the OR of flags ANDed with flag_mask, where a mask bit of 1 enables that flag.
- R7: While a frame runs, MDC toggles every mdc_ival+1 clocks and mdc_busy is high. MDC is low when idle. While mdc_en is low, MDC holds its level and no frame starts.
- R8: With poll_en high, a read of register 1 at poll_phy starts once the controller has been idle for (poll_ival+1)*POLL_UNIT clocks. The poll timer restarts after every frame.
- R9: A successful poll updates poll_status and sets the status-changed flag only when the value read differs from the stored copy.
- R10: The transceiver-detected flag is set by the first successful poll after reset, or after a failed poll. A failed poll sets no flag and leaves poll_status unchanged.
- R11: A command accepted during a poll frame waits until that frame completes, then runs.
- R12: After reset, cmd_lock, flags, irq, mdc, mdio_oe, mdc_busy, data_reg and poll_status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Command strobe |
| cmd_word | input | 11 | Write flag, transceiver address, register address |
| wr_data | input | 16 | Write value |
| cmd_lock | output | 1 | Command accepted and not finished |
| data_reg | output | 16 | Last write value or last read result |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| flag_mask | input | 4 | Interrupt enables |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Masked interrupt |
| poll_en | input | 1 | Auto-poll enable |
| poll_ival | input | 4 | Poll interval in POLL_UNIT clocks, minus one |
| poll_phy | input | 5 | Address polled |
| poll_status | output | 16 | Stored copy of the status register |
| mdc_en | input | 1 | MDC timer enable |
| mdc_ival | input | 8 | MDC half-period in clocks, minus one |
| mdc_busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Several rules are checked by assertions on every cycle:
- MDC stays low while no frame runs, and holds its level while the timer is disabled.
- The 32-bit preamble is driven as ones.
- cmd_lock only falls together with the command-complete flag.
- poll_status never changes without the status-changed flag.

Other behaviour can only be shown by the bench's scenarios, which run against a transceiver model in the bench:
- exact frame contents and line release;
- read data and turnaround errors;
- the MDC half-period length;
- the poll interval and change filtering;
- transceiver-detect rules;
- the rule that a software command waits behind a poll frame.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int POLL_UNIT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_go,
  input  logic [10:0] cmd_word,
  input  logic [15:0] wr_data,
  output logic        cmd_lock,
  output logic [15:0] data_reg,
  input  logic [3:0]  flag_clr,
  input  logic [3:0]  flag_mask,
  output logic [3:0]  flags,
  output logic        irq,
  input  logic        poll_en,
  input  logic [3:0]  poll_ival,
  input  logic [4:0]  poll_phy,
  output logic [15:0] poll_status,
  input  logic        mdc_en,
  input  logic [7:0]  mdc_ival,
  output logic        mdc_busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PCW = $clog2(16 * POLL_UNIT) + 1;

  logic          pend, busy, own_sw, fr_wr, ta_bad, seen;
  logic [10:0]   pcmd;
  logic [63:0]   sr;
  logic [5:0]    idx;
  logic [7:0]    hcnt;
  logic [15:0]   rx;
  logic [PCW-1:0] pcnt, plim;
  logic [3:0]    fset;

  function automatic logic [63:0] mk_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, pa, ra, wr ? 2'b10 : 2'b11, wr ? d : 16'hFFFF};
  endfunction

  assign cmd_lock = pend | (busy & own_sw);
  assign mdc_busy = busy;
  assign mdio_o   = sr[63];
  assign mdio_oe  = busy && (fr_wr || idx < 6'd46);
  assign irq      = |(flags & flag_mask);
  assign plim     = PCW'((32'(poll_ival) + 32'd1) * 32'(POLL_UNIT) - 32'd1);

  wire accept     = cmd_go && !cmd_lock;
  wire tick       = busy && mdc_en && hcnt == mdc_ival;
  wire last       = tick && mdc && idx == 6'd63;
  wire poll_due   = poll_en && pcnt == plim;
  wire start_sw   = !busy && mdc_en && pend;
  wire start_poll = !busy && mdc_en && !pend && poll_due;

  always_comb begin
    fset    = '0;
    fset[0] = last && own_sw;
    fset[1] = last && own_sw && !fr_wr && ta_bad;
    fset[2] = last && !own_sw && !ta_bad && rx != poll_status;
    fset[3] = last && !own_sw && !ta_bad && !seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; busy <= 1'b0; own_sw <= 1'b0; fr_wr <= 1'b0; ta_bad <= 1'b0; seen <= 1'b0;
      pcmd <= '0; sr <= '0; idx <= '0; hcnt <= '0; rx <= '0; pcnt <= '0; mdc <= 1'b0;
      data_reg <= '0; poll_status <= '0; flags <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | fset;
      if (accept) begin
        pend <= 1'b1;
        pcmd <= cmd_word;
        if (cmd_word[10]) data_reg <= wr_data;
      end
      if (busy || !poll_en || pend) pcnt <= '0;
      else if (!poll_due)           pcnt <= pcnt + 1'b1;
      if (start_sw || start_poll) begin
        busy   <= 1'b1;
        own_sw <= start_sw;
        fr_wr  <= start_sw && pcmd[10];
        sr     <= start_sw ? mk_frame(pcmd[10], pcmd[9:5], pcmd[4:0], data_reg)
                           : mk_frame(1'b0, poll_phy, 5'd1, 16'h0000);
        idx    <= '0;
        hcnt   <= '0;
        mdc    <= 1'b0;
        ta_bad <= 1'b0;
        if (start_sw) pend <= 1'b0;
      end else if (busy && mdc_en) begin
        hcnt <= tick ? 8'd0 : hcnt + 8'd1;
      end
      if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (idx == 6'd47) ta_bad <= mdio_i;
          if (idx >= 6'd48) rx <= {rx[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (idx == 6'd63) begin
            busy <= 1'b0;
            if (own_sw) begin
              if (!fr_wr && !ta_bad) data_reg <= rx;
            end else if (ta_bad) begin
              seen <= 1'b0;
            end else begin
              seen <= 1'b1;
              poll_status <= rx;
            end
          end else begin
            idx <= idx + 6'd1;
            sr  <= {sr[62:0], 1'b1};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdc_busy,
  input logic        mdc_en,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cmd_lock,
  input logic [3:0]  flags,
  input logic [15:0] poll_status,
  input logic [5:0]  idx
);
  a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_busy |-> !mdc);

  a_r7_mdc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_busy && !mdc_en) |=> $stable(mdc));

  a_r1_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_busy && idx < 6'd32) |-> (mdio_oe && mdio_o));

  a_r2_lock_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_lock) |-> flags[0]);

  a_r9_status_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(poll_status) |-> flags[2]);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdc_busy(mdc_busy), .mdc_en(mdc_en),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_lock(cmd_lock), .flags(flags),
  .poll_status(poll_status), .idx(idx)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 32;
  localparam logic [4:0] PHY_A = 5'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 1'b0, poll_en = 1'b0, mdc_en = 1'b1, mdio_i = 1'b1;
  logic [10:0] cmd_word = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  flag_clr = '0, flag_mask = '0, poll_ival = 4'd1;
  logic [4:0]  poll_phy = PHY_A;
  logic [7:0]  mdc_ival = 8'd0;
  logic        cmd_lock, irq, mdc_busy, mdc, mdio_o, mdio_oe;
  logic [15:0] data_reg, poll_status;
  logic [3:0]  flags;

  mdio_mgmt_ctrl #(.POLL_UNIT(UNIT)) u_mdio_mgmt_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, frames = 0, rises = 0;
  bit done_flag = 0;
  logic [15:0] model_regs [32];
  logic [63:0] cap, cap_oe, last_frame, last_oe;
  logic pm = 1'b0, rd_hit = 1'b0;
  logic [15:0] rd_val = '0;

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                                            input logic [15:0] d);
    logic [1:0] op = wr ? 2'b01 : 2'b10;
    logic [1:0] ta = wr ? 2'b10 : 2'b11;
    return {32'hFFFF_FFFF, 2'b01, op, pa, ra, ta, wr ? d : 16'hFFFF};
  endfunction

  function automatic logic [63:0] exp_oe(input logic wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
  endfunction

  // transceiver model
  always @(negedge clk) begin
    if (!mdc_busy) begin
      if (rises == 64) begin
        frames++;
        last_frame = cap;
        last_oe = cap_oe;
        if (cap[29:28] == 2'b01 && cap[27:23] == PHY_A) model_regs[cap[22:18]] = cap[15:0];
      end
      rises = 0;
      rd_hit = 1'b0;
      mdio_i = 1'b1;
    end else begin
      if (mdc && !pm) begin
        cap = {cap[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        rises++;
        if (rises == 46) begin
          rd_hit = (cap[11:10] == 2'b10) && (cap[9:5] == PHY_A);
          rd_val = model_regs[cap[4:0]];
        end
      end
      if (!mdc && pm) begin
        if (rd_hit && rises == 47) mdio_i = 1'b0;
        else if (rd_hit && rises >= 48 && rises < 64) mdio_i = rd_val[63 - rises];
        else mdio_i = 1'b1;
      end
    end
    pm = mdc;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    cmd_word = {wr, pa, ra};
    wr_data = d;
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_unlock();
    int n = 0;
    while (cmd_lock && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("R2 lock timeout", 1, 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wait_frames(input int k);
    int target = frames + k;
    int n = 0;
    while (frames < target && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("R8 poll timeout", 1, 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic clr_flags();
    flag_clr = 4'hF;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model_regs[i] = 16'(i * 16'h1111) ^ 16'hA5A5;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 lock", cmd_lock, 0);
    chk("R12 flags", flags, 0);
    chk("R12 irq", irq, 0);
    chk("R12 mdc", mdc, 0);
    chk("R12 oe", mdio_oe, 0);
    chk("R12 busy", mdc_busy, 0);
    chk("R12 data", data_reg, 0);
    chk("R12 status", poll_status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R4 lock, ignored second command, write value
    begin
      int f0 = frames;
      issue(1'b1, PHY_A, 5'd3, 16'h1234);
      chk("R2 lock set", cmd_lock, 1);
      chk("R4 data on accept", data_reg, 16'h1234);
      issue(1'b1, PHY_A, 5'd4, 16'hBEEF);
      wait_unlock();
      chk("R2 one frame", frames - f0, 1);
      chk("R2 ignored data", data_reg, 16'h1234);
      chk("R2 ignored reg", model_regs[4], 16'(4 * 16'h1111) ^ 16'hA5A5);
      chk("R1 write frame", last_frame, exp_frame(1'b1, PHY_A, 5'd3, 16'h1234));
      chk("R5 done flag", flags, 4'b0001);
    end

    // R6 masking, R5 clear
    flag_mask = 4'b0000; @(negedge clk); chk("R6 masked", irq, 0);
    flag_mask = 4'b0010; @(negedge clk); chk("R6 other bit", irq, 0);
    flag_mask = 4'b0001; @(negedge clk); chk("R6 enabled", irq, 1);
    flag_clr = 4'b0010; @(negedge clk); flag_clr = 0;
    chk("R5 clear other", flags, 4'b0001);
    flag_clr = 4'b0001; @(negedge clk); flag_clr = 0;
    chk("R5 w1c", flags, 4'b0000);
    chk("R6 irq low", irq, 0);
    flag_mask = 4'b0000;

    // R7 half period
    mdc_ival = 8'd3;
    issue(1'b0, PHY_A, 5'd2, 16'h0);
    begin
      int n = 0;
      while (!mdc) @(negedge clk);
      while (mdc && n < 100) begin @(negedge clk); n++; end
      chk("R7 half period", n, 4);
      chk("R7 busy high", mdc_busy, 1);
    end
    wait_unlock();
    clr_flags();

    // R7 timer disabled
    mdc_en = 1'b0;
    issue(1'b0, PHY_A, 5'd2, 16'h0);
    repeat (200) @(negedge clk);
    chk("R7 no start", mdc_busy, 0);
    chk("R7 still locked", cmd_lock, 1);
    chk("R7 mdc low", mdc, 0);
    mdc_en = 1'b1;
    wait_unlock();
    chk("R3 read after enable", data_reg, model_regs[2]);
    clr_flags();

    // random commands
    for (int i = 0; i < 30; i++) begin
      logic wr = 1'($urandom);
      logic [4:0] pa = ($urandom % 4 == 0) ? 5'd9 : PHY_A;
      logic [4:0] ra = 5'($urandom);
      logic [15:0] d = 16'($urandom);
      logic [15:0] prev = data_reg;
      logic [15:0] expv;
      mdc_ival = 8'($urandom % 3);
      if (ra == 5'd1) ra = 5'd6;
      issue(wr, pa, ra, d);
      wait_unlock();
      chk("R1 frame", last_frame, exp_frame(wr, pa, ra, d));
      chk("R1 line release", last_oe, exp_oe(wr));
      if (wr) begin
        chk("R4 write data", data_reg, d);
        chk("R5 write flags", flags, 4'b0001);
      end else if (pa == PHY_A) begin
        expv = model_regs[ra];
        chk("R3 read data", data_reg, expv);
        chk("R3 read flags", flags, 4'b0001);
      end else begin
        chk("R3 error keeps data", data_reg, prev);
        chk("R3 error flag", flags, 4'b0011);
      end
      clr_flags();
    end

    // auto-poll
    mdc_ival = 8'd0;
    model_regs[1] = 16'h782D;
    poll_phy = PHY_A;
    poll_ival = 4'd1;
    clr_flags();
    begin
      int n = 0;
      poll_en = 1'b1;
      while (!mdc_busy && n < 1000) begin @(negedge clk); n++; end
      chk("R8 poll wait", (n >= 63 && n <= 66) ? 1 : 0, 1);
    end
    wait_frames(1);
    chk("R1 poll frame", last_frame, exp_frame(1'b0, PHY_A, 5'd1, 16'h0));
    chk("R9 status copy", poll_status, 16'h782D);
    chk("R9 change flag", flags[2], 1);
    chk("R10 detect flag", flags[3], 1);
    clr_flags();
    wait_frames(2);
    chk("R9 no change no flag", flags, 4'b0000);
    model_regs[1] = 16'h7809;
    wait_frames(1);
    chk("R9 new status", poll_status, 16'h7809);
    chk("R9 flag on change", flags, 4'b0100);
    clr_flags();
    poll_phy = 5'd7;
    wait_frames(2);
    chk("R10 failed poll silent", flags, 4'b0000);
    chk("R10 status held", poll_status, 16'h7809);
    poll_phy = PHY_A;
    wait_frames(2);
    chk("R10 redetect", flags, 4'b1000);
    clr_flags();

    // R11 command during poll frame
    begin
      int n = 0;
      int f0;
      while (!(mdc_busy && !cmd_lock && rises < 10) && n < 2000) begin @(negedge clk); n++; end
      f0 = frames;
      issue(1'b1, PHY_A, 5'd12, 16'hC0DE);
      chk("R11 locked", cmd_lock, 1);
      wait_unlock();
      chk("R11 two frames", frames - f0, 2);
      chk("R11 sw frame last", last_frame, exp_frame(1'b1, PHY_A, 5'd12, 16'hC0DE));
      chk("R11 done", flags[0], 1);
    end
    poll_en = 1'b0;

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule